// File: doc/BRIEF.md
# Two-Region Flash Boot Loader

This block runs once after reset to find a usable application image in an external serial flash that holds two copies: one in the lower half and one in the upper half. It fetches the flash one byte at a time through a request/response port. An SPI master outside the block turns each request into flash traffic. The block checks a short header and the image bytes as they stream in. When a region passes, it reports which region was chosen. When both regions fail, it parks in an invalid-memory state and asks the system to route the debug port to the connector sideband pins.

The lower region is always tried first. Its read stops on the first byte that proves it bad, and the loader then starts over at the base of the upper region. While parked, the loader watches the bus-supply-valid input. A fresh rising edge on that input restarts the whole sequence from the lower region.

Each region starts with a 5-byte header, followed by the image bytes at region offset 5 onward:

- offsets 0 and 1 hold the 16-bit magic word, most significant byte first;
- offsets 2 and 3 hold the image length in bytes, most significant byte first;
- offset 4 holds the checksum: the sum of all image bytes, modulo 256.

Top module: `boot_image_loader`

## Requirements
- R1: While reset is asserted, `rd_req`, `boot_done`, `boot_hi` and `dbg_req` are 0. The first read after reset is for address `LO_BASE` (region offset 0).
- R2: A read is a one-cycle `rd_req` pulse. `rd_addr` equals the region base plus the offset, and the offsets go up by one from 0. The next request comes the cycle after the response is accepted.
- R3: Region offsets 0 and 1 must equal `MAGIC[15:8]` and `MAGIC[7:0]`. A mismatch makes the region invalid.
- R4: Offsets 2 and 3 give a 16-bit length, most significant byte first. A length above half the flash size minus 5 is invalid. A length exactly equal to that limit is accepted.
- R5: Offset 4 must equal the modulo-256 sum of the image bytes at offsets 5 through 4+length. The region is valid once its last image byte has been read and the sum matches. A zero length needs a checksum byte of 0.
- R6: The first invalid byte ends that region's reads. After a lower-region failure, the next request goes to offset 0 of `HI_BASE` (half the flash by default).
- R7: A response with `rd_vld` is accepted in any of the `TIMEOUT` cycles after the request. If no response arrives in that window, the region is invalid.
- R8: On success, `boot_done` goes to 1 and stays there. `boot_hi` is 1 when the upper region was chosen. No further reads are made.
- R9: When both regions are invalid, `dbg_req` goes to 1, `boot_done` stays 0 and no reads are made.
- R10: In the invalid-memory state, a 0-to-1 change on `bus_ok` restarts the search at the lower region. A steady level of `bus_ok` has no effect, and neither do its edges in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ok | input | 1 | Bus supply valid |
| rd_req | output | 1 | Byte read request pulse |
| rd_addr | output | AW | Flash byte address |
| rd_vld | input | 1 | Read response strobe |
| rd_data | input | 8 | Read response byte |
| boot_done | output | 1 | A valid region was found |
| boot_hi | output | 1 | Chosen region is the upper one (with boot_done) |
| dbg_req | output | 1 | Both regions invalid; expose the debug port |

## Verification
The bench builds the loader with an 8-bit address (two 128-byte regions), a timeout of 6 cycles and magic word 0xC3A5. With these values, a region filled to its maximum length of 123 bytes can be read end to end. A response latency of exactly 6 or 7 cycles places the acceptance window edge on both sides. A flash model with adjustable latency and an address that never answers reaches every failure path in both regions, including the restart after the invalid-memory state.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

  typedef enum logic [2:0] {
    LDR_IDLE    = 3'd0,
    LDR_READ_LO = 3'd1,
    LDR_READ_HI = 3'd2,
    LDR_DONE    = 3'd3,
    LDR_INVALID = 3'd4
  } ldr_state_e;

  // header layout, byte offsets within a region
  localparam int HDR_BYTES  = 5;
  localparam int OFS_MAG_HI = 0;
  localparam int OFS_MAG_LO = 1;
  localparam int OFS_LEN_HI = 2;
  localparam int OFS_LEN_LO = 3;
  localparam int OFS_CSUM   = 4;
  localparam int LEN_W      = 16;

endpackage

// File: rtl/bl_wait_timer.sv
module bl_wait_timer #(
  parameter int TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic waiting,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en  = start | waiting;
  assign cnt_d   = start ? '0 : cnt_q + 1'b1;
  assign expired = waiting && (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: a pending read never waits past the window
  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt_q <= LIM));

endmodule

// File: rtl/bl_rise_det.sv
module bl_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign rise = din && !prev_q;

endmodule

// File: rtl/bl_image_check.sv
module bl_image_check import boot_ldr_pkg::*; #(
  parameter int          AW    = 16,
  parameter logic [15:0] MAGIC = 16'hC3A5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            byte_en,
  input  logic [AW-2:0]   idx,
  input  logic [7:0]      data,
  output logic            bad,
  output logic            last
);
  localparam int OFF_W   = AW - 1;
  localparam int MAX_LEN = (2 ** (AW - 1)) - HDR_BYTES;

  logic [7:0]       len_hi_q, ck_q, sum_q;
  logic [LEN_W-1:0] len_q, len_now;
  logic [7:0]       sum_nx;
  logic [LEN_W:0]   idx_x, end_x;

  assign len_now = {len_hi_q, data};
  assign sum_nx  = sum_q + data;
  assign idx_x   = (LEN_W + 1)'(idx);
  assign end_x   = (LEN_W + 1)'(len_q) + (LEN_W + 1)'(OFS_CSUM);

  always_comb begin
    bad  = 1'b0;
    last = 1'b0;
    if (idx == OFF_W'(OFS_MAG_HI)) begin
      bad = (data != MAGIC[15:8]);
    end else if (idx == OFF_W'(OFS_MAG_LO)) begin
      bad = (data != MAGIC[7:0]);
    end else if (idx == OFF_W'(OFS_LEN_LO)) begin
      bad = (len_now > LEN_W'(MAX_LEN));
    end else if (idx == OFF_W'(OFS_CSUM)) begin
      last = (len_q == '0);
      bad  = last && (data != 8'h00);
    end else if (idx > OFF_W'(OFS_CSUM)) begin
      last = (idx_x == end_x);
      bad  = last && (sum_nx != ck_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_hi_q <= '0;
      len_q    <= '0;
      ck_q     <= '0;
      sum_q    <= '0;
    end else if (clr) begin
      sum_q <= '0;
    end else if (byte_en) begin
      if (idx == OFF_W'(OFS_LEN_HI)) len_hi_q <= data;
      if (idx == OFF_W'(OFS_LEN_LO)) len_q    <= len_now;
      if (idx == OFF_W'(OFS_CSUM))   ck_q     <= data;
      if (idx >  OFF_W'(OFS_CSUM))   sum_q    <= sum_nx;
    end
  end

endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader import boot_ldr_pkg::*; #(
  parameter int           AW      = 16,   // up to 17: the length field is 16 bits
  parameter int           TIMEOUT = 1000,
  parameter logic [15:0]  MAGIC   = 16'hC3A5,
  parameter logic [AW-1:0] LO_BASE = '0,
  parameter logic [AW-1:0] HI_BASE = AW'(1) << (AW - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ok,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_vld,
  input  logic [7:0]    rd_data,
  output logic          boot_done,
  output logic          boot_hi,
  output logic          dbg_req
);
  localparam int OFF_W = AW - 1;

  ldr_state_e       st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             pend_q, pend_d;
  logic             hi_q, hi_d;
  logic             clr, byte_en, fail;
  logic             bad, last, expired, rise, waiting;

  assign rd_req    = ((st_q == LDR_READ_LO) || (st_q == LDR_READ_HI)) && !pend_q;
  assign rd_addr   = ((st_q == LDR_READ_HI) ? HI_BASE : LO_BASE) + AW'(off_q);
  assign waiting   = pend_q && !rd_vld;
  assign boot_done = (st_q == LDR_DONE);
  assign boot_hi   = (st_q == LDR_DONE) && hi_q;
  assign dbg_req   = (st_q == LDR_INVALID);

  bl_image_check #(.AW(AW), .MAGIC(MAGIC)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_en(byte_en),
    .idx(off_q), .data(rd_data), .bad(bad), .last(last)
  );

  bl_wait_timer #(.TIMEOUT(TIMEOUT)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(rd_req), .waiting(waiting), .expired(expired)
  );

  bl_rise_det edge_i (
    .clk(clk), .rst_n(rst_n), .din(bus_ok), .rise(rise)
  );

  always_comb begin
    st_d    = st_q;
    off_d   = off_q;
    pend_d  = pend_q;
    hi_d    = hi_q;
    clr     = 1'b0;
    byte_en = 1'b0;
    fail    = 1'b0;
    unique case (st_q)
      LDR_IDLE: begin
        st_d   = LDR_READ_LO;
        off_d  = '0;
        pend_d = 1'b0;
        clr    = 1'b1;
      end
      LDR_READ_LO, LDR_READ_HI: begin
        if (!pend_q) begin
          pend_d = 1'b1;
        end else if (rd_vld) begin
          byte_en = 1'b1;
          pend_d  = 1'b0;
          off_d   = off_q + 1'b1;
          if (bad) begin
            fail = 1'b1;
          end else if (last) begin
            st_d = LDR_DONE;
            hi_d = (st_q == LDR_READ_HI);
          end
        end else if (expired) begin
          fail = 1'b1;
        end
        if (fail) begin
          pend_d = 1'b0;
          off_d  = '0;
          clr    = 1'b1;
          st_d   = (st_q == LDR_READ_LO) ? LDR_READ_HI : LDR_INVALID;
        end
      end
      LDR_INVALID: begin
        if (rise) begin
          st_d   = LDR_READ_LO;
          off_d  = '0;
          pend_d = 1'b0;
          clr    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LDR_IDLE;
      off_q  <= '0;
      pend_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      off_q  <= off_d;
      pend_q <= pend_d;
      hi_q   <= hi_d;
    end
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !rd_req && !dbg_req);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  assert_inv_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> !rd_req && !boot_done);
  assert_hi_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && st_q == LDR_READ_HI) |-> (rd_addr >= HI_BASE));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && rise) |=> (st_q == LDR_READ_LO));

endmodule

// File: tb/boot_image_loader_tb_top.sv
module boot_image_loader_tb_top;
  localparam int AW   = 8;
  localparam int TO   = 6;
  localparam int MAG  = 16'hC3A5;
  localparam int HALF = 128;
  localparam int MAXL = HALF - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ok = 1'b0;
  logic rd_req, rd_vld = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic boot_done, boot_hi, dbg_req;

  always #5 clk = ~clk;

  boot_image_loader #(.AW(AW), .TIMEOUT(TO), .MAGIC(16'hC3A5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_vld(rd_vld), .rd_data(rd_data), .boot_done(boot_done), .boot_hi(boot_hi),
    .dbg_req(dbg_req)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [256];
  int lat = 1, dead_addr = -1, rsp_cnt = 0, rsp_addr = 0;
  int lo_reads = 0, first_addr = -1;
  // behavioural reference state
  int ms, moff, mpend, mwait, mlen, mlenhi, mck, msum, mhi, mprev;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ms = 0; moff = 0; mpend = 0; mwait = 0; mlen = 0; mlenhi = 0;
    mck = 0; msum = 0; mhi = 0; mprev = 0;
  endtask

  task automatic model_fail();
    mpend = 0; moff = 0; msum = 0;
    ms = (ms == 1) ? 2 : 4;
  endtask

  task automatic model_step();
    bit rise, bad, fin;
    int d, o;
    rise = bus_ok && (mprev == 0);
    mprev = bus_ok ? 1 : 0;
    case (ms)
      0: begin ms = 1; moff = 0; mpend = 0; msum = 0; end
      1, 2: begin
        if (mpend == 0) begin
          mpend = 1; mwait = 0;
        end else if (rd_vld) begin
          d = rd_data; o = moff; moff++; mpend = 0; bad = 0; fin = 0;
          if (o == 0) bad = (d != (MAG >> 8));
          else if (o == 1) bad = (d != (MAG & 255));
          else if (o == 2) mlenhi = d;
          else if (o == 3) begin mlen = mlenhi * 256 + d; bad = (mlen > MAXL); end
          else if (o == 4) begin mck = d; if (mlen == 0) begin fin = 1; bad = (d != 0); end end
          else begin
            msum = (msum + d) & 255;
            if (o == mlen + 4) begin fin = 1; bad = (msum != mck); end
          end
          if (bad) model_fail();
          else if (fin) begin mhi = (ms == 2); ms = 3; end
        end else if (mwait == TO - 1) model_fail();
        else mwait++;
      end
      4: if (rise) begin ms = 1; moff = 0; mpend = 0; msum = 0; end
      default: ;
    endcase
  endtask

  // flash responder, per-cycle comparison and reference step
  initial begin
    model_reset();
    forever begin
      @(negedge clk);
      cyc++;
      rd_vld = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin rd_vld = 1'b1; rd_data = mem[rsp_addr]; end
      end
      if (rst_n && rd_req) begin
        if (int'(rd_addr) != dead_addr) begin rsp_cnt = lat; rsp_addr = rd_addr; end
        else rsp_cnt = 0;
        if (rd_addr < HALF) lo_reads++;
        if (first_addr < 0) first_addr = rd_addr;
      end
      if (rst_n) begin
        bit e_req; int e_addr;
        e_req  = (ms == 1 || ms == 2) && mpend == 0;
        e_addr = ((ms == 2) ? HALF : 0) + moff;
        chk(rd_req == e_req && (!e_req || int'(rd_addr) == e_addr),
            "R2 request/address", e_req ? int'(rd_addr) : int'(rd_req), e_req ? e_addr : 0);
        chk(boot_done == (ms == 3) && boot_hi == (ms == 3 && mhi != 0),
            "R8 done/hi", {boot_done, boot_hi}, {ms == 3, ms == 3 && mhi != 0});
        chk(dbg_req == (ms == 4), "R9 debug request", dbg_req, ms == 4);
        model_step();
      end else model_reset();
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic erase();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  task automatic put_img(int base, int len, bit bad_mag, int ck_delta);
    int s = 0, b;
    mem[base]     = 8'(MAG >> 8);
    mem[base + 1] = bad_mag ? 8'((MAG & 255) ^ 1) : 8'(MAG & 255);
    mem[base + 2] = 8'(len >> 8);
    mem[base + 3] = 8'(len & 255);
    for (int i = 0; i < len && 5 + i < HALF; i++) begin
      b = (i * 7 + base + 3) & 255;
      mem[base + 5 + i] = 8'(b);
      s += b;
    end
    mem[base + 4] = 8'((s + ck_delta) & 255);
  endtask

  task automatic do_reset(int l, int dead);
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!rd_req && !boot_done && !boot_hi && !dbg_req, "R1 reset outputs",
        {rd_req, boot_done, boot_hi, dbg_req}, 0);
    @(posedge clk); #1;
    lat = l; dead_addr = dead; lo_reads = 0; first_addr = -1;
    rst_n = 1'b1;
  endtask

  task automatic wait_end(bit wiggle);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (wiggle && (i % 5 == 0)) bus_ok = !bus_ok;
      @(negedge clk);
      if (boot_done || dbg_req) break;
    end
  endtask

  initial begin
    bus_ok = 1'b1;
    // S1: valid lower image
    erase(); put_img(0, 4, 0, 0);
    do_reset(1, -1); wait_end(0);
    chk(boot_done && !boot_hi, "R5 lower image chosen", {boot_done, boot_hi}, 2);
    chk(first_addr == 0, "R1 first read at lower base", first_addr, 0);
    // S2: bad second magic byte in lower, zero-length upper
    erase(); put_img(0, 4, 1, 0); put_img(HALF, 0, 0, 0);
    do_reset(1, -1); wait_end(0);
    chk(boot_done && boot_hi, "R3 magic mismatch falls back", {boot_done, boot_hi}, 3);
    chk(lo_reads == 2, "R6 lower aborted at first bad byte", lo_reads, 2);
    // S3: lower length one above limit
    erase(); put_img(0, MAXL + 1, 0, 0); put_img(HALF, 10, 0, 0);
    do_reset(2, -1); wait_end(0);
    chk(boot_done && boot_hi, "R4 oversize length rejected", {boot_done, boot_hi}, 3);
    chk(lo_reads == 4, "R4 abort after length byte", lo_reads, 4);
    // S4: lower length at limit, bus_ok toggling during reads
    erase(); put_img(0, MAXL, 0, 0);
    do_reset(1, -1); wait_end(1);
    chk(boot_done && !boot_hi, "R4 max length accepted", {boot_done, boot_hi}, 2);
    chk(lo_reads == HALF, "R10 edges ignored while reading", lo_reads, HALF);
    bus_ok = 1'b1;
    // S5: both checksums wrong, then restart
    erase(); put_img(0, 6, 0, 1); put_img(HALF, 3, 0, 255);
    do_reset(1, -1); wait_end(0);
    chk(dbg_req && !boot_done, "R9 both invalid", {dbg_req, boot_done}, 2);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(dbg_req && !rd_req, "R10 steady level ignored", {dbg_req, rd_req}, 2);
    @(posedge clk); #1; bus_ok = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(dbg_req, "R10 falling edge ignored", dbg_req, 1);
    put_img(0, 6, 0, 0);
    @(posedge clk); #1; bus_ok = 1'b1; lo_reads = 0;
    wait_end(0);
    chk(boot_done && !boot_hi, "R10 restart finds lower image", {boot_done, boot_hi}, 2);
    chk(lo_reads == 11, "R5 full lower read after restart", lo_reads, 11);
    // S6: latency exactly at timeout
    erase(); put_img(0, 3, 0, 0);
    do_reset(TO, -1); wait_end(0);
    chk(boot_done && !boot_hi, "R7 response at window edge", {boot_done, boot_hi}, 2);
    // S7: latency one beyond timeout
    do_reset(TO + 1, -1); wait_end(0);
    chk(dbg_req, "R7 late responses invalid", dbg_req, 1);
    chk(lo_reads == 1, "R7 lower abandoned after one read", lo_reads, 1);
    // S8: silent address in lower header
    erase(); put_img(0, 3, 0, 0); put_img(HALF, 2, 0, 0);
    do_reset(2, 3); wait_end(0);
    chk(boot_done && boot_hi, "R7 silent read falls back", {boot_done, boot_hi}, 3);
    chk(lo_reads == 4, "R6 no lower reads after timeout", lo_reads, 4);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule